// File: doc/BRIEF.md
# Cache Maintenance Control Register Block

This block is the memory-mapped control and status slave for a shared second-level cache. Software reaches it through a simple word-wide write/read port. It offers a read-only geometry word, a status word, a command register and a page-clear register. It also holds a limit on outstanding reads, an enable register, and two event counters, each with its own source-select register. Reads are combinational on the offset presented. Writes take effect at the clock edge on which the write strobe is high.

A one-shot command engine drives a request/done handshake toward the cache array. Writing the clear-all code to the command register starts a whole-cache clear. Writing an address to the page-clear register starts a clear of that one page. The engine has three states. `ST_IDLE` waits for a command. `ST_ISSUE` lasts one cycle and raises the request. `ST_WAIT` holds until the array reports done. Its transitions are: accept (`ST_IDLE`→`ST_ISSUE` on a valid command write), issue (`ST_ISSUE`→`ST_WAIT`, unconditional) and complete (`ST_WAIT`→`ST_IDLE` on done). Command writes that arrive while the engine is not idle are dropped.

Each event counter counts one strobe out of a vector of event strobes, chosen by its source register. It can be reloaded, or restarted by writing zero, through its value register.

Top module: `cache_maint_regs`

## Requirements
- R1: After reset, status, enable, outstanding-read limit, both counter sources and both counter values read 0, `enable_o` and `max_reads_o` are 0, and `clr_req_o` is low.
- R2: Offset 0x04 reads the geometry word: log2 line bytes in bits 7:0, log2 ways in bits 15:8, log2 total bytes in bits 23:16, log2 external bus bits in bits 31:24. Writes to it are ignored.
- R3: Writing 0x01 to offset 0x10 while idle raises status bit 0 on the next cycle. In that same cycle a single-cycle `clr_req_o` pulse appears with `clr_page_o` = 0.
- R4: Writing a value to offset 0x14 while idle starts a page clear. The request pulse appears on the next cycle with `clr_page_o` = 1 and `clr_addr_o` equal to the written value.
- R5: After the request, the engine stays busy until `clr_done_i` is seen high. Status bit 0 reads 0 from the following cycle.
- R6: Command or page-clear writes made while status bit 0 is set are dropped. They cause no further request, and `clr_addr_o`/`clr_page_o` keep their values.
- R7: Writing any value other than 0x01 to offset 0x10 starts nothing.
- R8: Status bit 1 reads the level of `data_busy_i`. Status bits 31:2 read 0, and the status register ignores writes.
- R9: Offset 0x1C holds two enable bits (bit 0 access, bit 1 read allocate) that drive `enable_o`. Higher bits read 0.
- R10: Offset 0x18 holds the outstanding-read limit (low `MAXRD_W` bits), which drives `max_reads_o`.
- R11: A counter source (0x20 for counter 0, 0x28 for counter 1) of 0 disables counting. A source s from 1 to `NUM_EVT` adds one per cycle in which `evt_i[s-1]` is high. A source above `NUM_EVT` counts nothing.
- R12: Writing a counter value register (0x24, 0x2C) loads the written value, so writing 0 restarts the count. A write wins over an event in the same cycle.
- R13: Counters wrap from 0xFFFFFFFF to 0 with no other effect.
- R14: Offsets 0x00, 0x0C and 0x30–0x3F, and any offset with bits 1:0 nonzero, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| data_busy_i | input | 1 | Data traffic busy from the cache array |
| evt_i | input | NUM_EVT | Event strobes available to the counters |
| clr_req_o | output | 1 | Single-cycle clear request |
| clr_page_o | output | 1 | 1: page clear, 0: whole-cache clear |
| clr_addr_o | output | 32 | Page address of the current clear |
| clr_done_i | input | 1 | Clear completion from the cache array |
| enable_o | output | 2 | Bit 0 access enable, bit 1 read allocate |
| max_reads_o | output | MAXRD_W | Outstanding-read limit |

## Verification
The bench builds the block with its default parameters: `NUM_EVT` = 8 and `MAXRD_W` = 8. The geometry values are 6, 4, 17 and 7, which are distinct, so a misplaced geometry field shows up in the read value. Eight event strobes make a source of 9 legal to write but out of range, which reaches the "counts nothing" branch. The 8-bit limit shows truncation of a wider write. Counter 1 is preloaded close to the top of its range, which brings the wrap within a few cycles.

// File: rtl/cmm_pkg.sv
package cmm_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    // word indices (byte offset / 4)
    localparam logic [3:0] WI_GEOM   = 4'h1;
    localparam logic [3:0] WI_STATUS = 4'h2;
    localparam logic [3:0] WI_CMD    = 4'h4;
    localparam logic [3:0] WI_PAGE   = 4'h5;
    localparam logic [3:0] WI_MAXRD  = 4'h6;
    localparam logic [3:0] WI_ENA    = 4'h7;
    localparam logic [3:0] WI_SRC0   = 4'h8;
    localparam logic [3:0] WI_VAL0   = 4'h9;
    localparam logic [3:0] WI_SRC1   = 4'hA;
    localparam logic [3:0] WI_VAL1   = 4'hB;

    localparam logic [DATA_W-1:0] CODE_CLEAR_ALL = 32'h0000_0001;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } eng_state_e;
endpackage

// File: rtl/cmm_cmd_engine.sv
module cmm_cmd_engine
    import cmm_pkg::*;
#(
    parameter int PA_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_all,
    input  logic            start_page,
    input  logic [PA_W-1:0] page_addr,
    input  logic            clr_done,
    output logic            busy,
    output logic            clr_req,
    output logic            clr_page,
    output logic [PA_W-1:0] clr_addr
);
    eng_state_e state_q, state_d;
    logic       accept;

    assign accept = (state_q == ST_IDLE) && (start_all || start_page);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)   state_d = ST_ISSUE;
            ST_ISSUE:               state_d = ST_WAIT;
            ST_WAIT:  if (clr_done) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            clr_page <= 1'b0;
            clr_addr <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                clr_page <= start_page;
                clr_addr <= start_page ? page_addr : '0;
            end
        end
    end

    always_comb begin
        busy    = 1'b1;
        clr_req = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy    = 1'b0;
            ST_ISSUE: clr_req = 1'b1;
            ST_WAIT:  clr_req = 1'b0;
            default:  busy    = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmm_event_counter.sv
module cmm_event_counter #(
    parameter int NUM_EVT = 8,
    parameter int SRC_W   = 8,
    parameter int CNT_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_src,
    input  logic               wr_val,
    input  logic [CNT_W-1:0]   wdata,
    input  logic [NUM_EVT-1:0] evt,
    output logic [SRC_W-1:0]   src,
    output logic [CNT_W-1:0]   count
);
    logic hit;

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (src == SRC_W'(i + 1)) hit = evt[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src   <= '0;
            count <= '0;
        end else begin
            if (wr_src) src <= wdata[SRC_W-1:0];
            if (wr_val)   count <= wdata;
            else if (hit) count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/cache_maint_regs.sv
module cache_maint_regs
    import cmm_pkg::*;
#(
    parameter int NUM_EVT    = 8,
    parameter int MAXRD_W    = 8,
    parameter int SRC_W      = 8,
    parameter int LINE_LOG2  = 6,
    parameter int WAYS_LOG2  = 4,
    parameter int BYTES_LOG2 = 17,
    parameter int BUS_LOG2   = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr_en,
    input  logic [5:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic                data_busy_i,
    input  logic [NUM_EVT-1:0]  evt_i,
    output logic                clr_req_o,
    output logic                clr_page_o,
    output logic [31:0]         clr_addr_o,
    input  logic                clr_done_i,
    output logic [1:0]          enable_o,
    output logic [MAXRD_W-1:0]  max_reads_o
);
    localparam int NUM_CNT = 2;
    localparam logic [DATA_W-1:0] GEOM_WORD = {8'(BUS_LOG2), 8'(BYTES_LOG2),
                                               8'(WAYS_LOG2), 8'(LINE_LOG2)};

    logic [3:0]         widx;
    logic               aligned;
    logic               wr_ok;
    logic               cmd_busy;
    logic [1:0]         enable_q;
    logic [MAXRD_W-1:0] maxrd_q;
    logic [SRC_W-1:0]   src_q [NUM_CNT];
    logic [DATA_W-1:0]  cnt_q [NUM_CNT];
    logic [SRC_W-1:0]   src0;
    logic [DATA_W-1:0]  cnt0;

    assign widx    = bus_addr[5:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_ok   = bus_wr_en && aligned;

    cmm_cmd_engine #(.PA_W(DATA_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_all  (wr_ok && widx == WI_CMD && bus_wdata == CODE_CLEAR_ALL),
        .start_page (wr_ok && widx == WI_PAGE),
        .page_addr  (bus_wdata),
        .clr_done   (clr_done_i),
        .busy       (cmd_busy),
        .clr_req    (clr_req_o),
        .clr_page   (clr_page_o),
        .clr_addr   (clr_addr_o)
    );

    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
        localparam logic [3:0] SRC_IDX = (c == 0) ? WI_SRC0 : WI_SRC1;
        localparam logic [3:0] VAL_IDX = (c == 0) ? WI_VAL0 : WI_VAL1;
        cmm_event_counter #(
            .NUM_EVT (NUM_EVT),
            .SRC_W   (SRC_W),
            .CNT_W   (DATA_W)
        ) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_src (wr_ok && widx == SRC_IDX),
            .wr_val (wr_ok && widx == VAL_IDX),
            .wdata  (bus_wdata),
            .evt    (evt_i),
            .src    (src_q[c]),
            .count  (cnt_q[c])
        );
    end

    assign src0 = src_q[0];
    assign cnt0 = cnt_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            maxrd_q  <= '0;
        end else if (wr_ok) begin
            if (widx == WI_ENA)   enable_q <= bus_wdata[1:0];
            if (widx == WI_MAXRD) maxrd_q  <= bus_wdata[MAXRD_W-1:0];
        end
    end

    assign enable_o    = enable_q;
    assign max_reads_o = maxrd_q;

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (widx)
                WI_GEOM:   bus_rdata = GEOM_WORD;
                WI_STATUS: bus_rdata = {30'd0, data_busy_i, cmd_busy};
                WI_MAXRD:  bus_rdata = DATA_W'(maxrd_q);
                WI_ENA:    bus_rdata = {30'd0, enable_q};
                WI_SRC0:   bus_rdata = DATA_W'(src_q[0]);
                WI_VAL0:   bus_rdata = cnt_q[0];
                WI_SRC1:   bus_rdata = DATA_W'(src_q[1]);
                WI_VAL1:   bus_rdata = cnt_q[1];
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cmm_checker.sv
module cmm_checker #(
    parameter int SRC_W = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        clr_req,
    input logic        clr_done,
    input logic        wr_en,
    input logic [5:0]  addr,
    input logic [1:0]  enable,
    input logic [SRC_W-1:0] src0,
    input logic [31:0] cnt0
);
    AST_REQ_ON_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> clr_req); // R3
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) clr_req |=> !clr_req); // R3
    AST_REQ_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n) clr_req |-> !$past(busy)); // R6
    AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (busy && !clr_req) |=> !clr_req); // R6
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (busy && !clr_req && clr_done) |=> !busy); // R5
    AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !(wr_en && addr == 6'h1C) |=> $stable(enable)); // R9
    AST_CNT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) (src0 == '0 && !(wr_en && addr == 6'h24)) |=> $stable(cnt0)); // R11
endmodule

bind cache_maint_regs cmm_checker #(.SRC_W(SRC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (cmd_busy),
    .clr_req  (clr_req_o),
    .clr_done (clr_done_i),
    .wr_en    (bus_wr_en),
    .addr     (bus_addr),
    .enable   (enable_o),
    .src0     (src0),
    .cnt0     (cnt0)
);

// File: tb/cache_maint_regs_tb.sv
module cache_maint_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_EVT = 8;
    localparam int MAXRD_W = 8;
    localparam int NV = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_wr_en = 1'b0;
    logic [5:0]         bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic               data_busy_i = 1'b0;
    logic [NUM_EVT-1:0] evt_i = '0;
    logic               clr_req_o, clr_page_o, clr_done_i = 1'b0;
    logic [31:0]        clr_addr_o;
    logic [1:0]         enable_o;
    logic [MAXRD_W-1:0] max_reads_o;

    int checks = 0;
    int fails = 0;
    int req_cnt = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_maint_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .data_busy_i(data_busy_i),
        .evt_i(evt_i), .clr_req_o(clr_req_o), .clr_page_o(clr_page_o),
        .clr_addr_o(clr_addr_o), .clr_done_i(clr_done_i), .enable_o(enable_o),
        .max_reads_o(max_reads_o)
    );

    always @(posedge clk) if (rst_n && clr_req_o) req_cnt++;

    // {write, addr, wdata, expected read}
    localparam logic [70:0] VEC [NV] = '{
        {1'b0, 6'h04, 32'h0,          32'h0711_0406},  // R2
        {1'b1, 6'h04, 32'hFFFF_FFFF,  32'h0711_0406},  // R2
        {1'b1, 6'h08, 32'hFFFF_FFFF,  32'h0000_0000},  // R8
        {1'b1, 6'h1C, 32'hFFFF_FFFF,  32'h0000_0003},  // R9
        {1'b1, 6'h1C, 32'h0000_0002,  32'h0000_0002},  // R9
        {1'b1, 6'h18, 32'h0000_1234,  32'h0000_0034},  // R10
        {1'b1, 6'h0C, 32'h0000_DEAD,  32'h0000_0000},  // R14
        {1'b1, 6'h00, 32'h0000_BEEF,  32'h0000_0000},  // R14
        {1'b1, 6'h30, 32'h1111_1111,  32'h0000_0000},  // R14
        {1'b1, 6'h3C, 32'h2222_2222,  32'h0000_0000},  // R14
        {1'b1, 6'h1D, 32'h0000_0001,  32'h0000_0000},  // R14
        {1'b1, 6'h19, 32'h0000_0077,  32'h0000_0000},  // R14
        {1'b1, 6'h28, 32'h0000_0105,  32'h0000_0005},  // R11
        {1'b1, 6'h2C, 32'hCAFE_F00D,  32'hCAFE_F00D},  // R12
        {1'b0, 6'h18, 32'h0,          32'h0000_0034},  // R10, R14
        {1'b0, 6'h1C, 32'h0,          32'h0000_0002}   // R9, R14
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int rc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 clr_req", 32'(clr_req_o), 0);
        check("R1 enable_o", 32'(enable_o), 0);
        check("R1 max_reads_o", 32'(max_reads_o), 0);
        rd(6'h08, r); check("R1 status", r, 0);
        rd(6'h1C, r); check("R1 enable", r, 0);
        rd(6'h18, r); check("R1 maxrd", r, 0);
        rd(6'h20, r); check("R1 src0", r, 0);
        rd(6'h24, r); check("R1 val0", r, 0);
        rd(6'h28, r); check("R1 src1", r, 0);
        rd(6'h2C, r); check("R1 val1", r, 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][70]) wr(VEC[i][69:64], VEC[i][63:32]);
            rd(VEC[i][69:64], r);
            check($sformatf("table[%0d] R2/R8/R9/R10/R11/R12/R14", i), r, VEC[i][31:0]);
        end
        check("R9 enable_o", 32'(enable_o), 2);
        check("R10 max_reads_o", 32'(max_reads_o), 32'h34);

        // R8 data busy
        data_busy_i = 1'b1;
        rd(6'h08, r); check("R8 status data busy", r, 2);
        data_busy_i = 1'b0;

        // R3 clear all
        rc = req_cnt;
        wr(6'h10, 32'h1);
        check("R3 req pulse", 32'(clr_req_o), 1);
        check("R3 page flag", 32'(clr_page_o), 0);
        rd(6'h08, r); check("R3 busy set", r, 1);
        @(negedge clk);
        check("R3 req single", 32'(clr_req_o), 0);
        // R6 commands while busy dropped
        wr(6'h14, 32'h0009_9000);
        wr(6'h10, 32'h1);
        repeat (2) @(negedge clk);
        check("R6 no extra req", 32'(req_cnt - rc), 1);
        check("R6 page flag held", 32'(clr_page_o), 0);
        check("R6 addr held", clr_addr_o, 0);
        rd(6'h08, r); check("R5 busy until done", r, 1);
        // R5 done
        clr_done_i = 1'b1;
        @(negedge clk);
        clr_done_i = 1'b0;
        rd(6'h08, r); check("R5 busy cleared", r, 0);

        // R7 other codes
        rc = req_cnt;
        wr(6'h10, 32'h2);
        wr(6'h10, 32'h0);
        repeat (2) @(negedge clk);
        rd(6'h08, r); check("R7 not busy", r, 0);
        check("R7 no req", 32'(req_cnt - rc), 0);

        // R4 page clear
        rc = req_cnt;
        wr(6'h14, 32'h0004_5000);
        check("R4 req pulse", 32'(clr_req_o), 1);
        check("R4 page flag", 32'(clr_page_o), 1);
        check("R4 page addr", clr_addr_o, 32'h0004_5000);
        wr(6'h14, 32'h0007_7000);
        @(negedge clk);
        check("R6 page addr kept", clr_addr_o, 32'h0004_5000);
        check("R4 one req", 32'(req_cnt - rc), 1);
        clr_done_i = 1'b1;
        @(negedge clk);
        clr_done_i = 1'b0;
        rd(6'h08, r); check("R5 page busy cleared", r, 0);

        // R11 counting
        wr(6'h20, 32'h3);
        evt_i = 8'b0000_0100;
        repeat (5) @(negedge clk);
        evt_i = 8'b0000_0001;
        repeat (3) @(negedge clk);
        evt_i = '0;
        rd(6'h24, r); check("R11 count selected event", r, 5);
        // source out of range
        wr(6'h20, 32'h9);
        evt_i = 8'hFF;
        repeat (4) @(negedge clk);
        evt_i = '0;
        rd(6'h24, r); check("R11 out of range counts nothing", r, 5);
        // source 0 disabled
        wr(6'h20, 32'h0);
        evt_i = 8'hFF;
        repeat (4) @(negedge clk);
        evt_i = '0;
        rd(6'h24, r); check("R11 source 0 disabled", r, 5);
        // R12 restart with zero
        wr(6'h24, 32'h0);
        rd(6'h24, r); check("R12 restart", r, 0);

        // R12 write wins over event; R13 wrap
        wr(6'h28, 32'h1);
        evt_i = 8'h01;
        wr(6'h2C, 32'h7);
        evt_i = '0;
        rd(6'h2C, r); check("R12 write wins", r, 7);
        wr(6'h2C, 32'hFFFF_FFFE);
        evt_i = 8'h01;
        repeat (3) @(negedge clk);
        evt_i = '0;
        rd(6'h2C, r); check("R13 wrap", r, 1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule